// File: doc/BRIEF.md
# Division Setup Stage

This block prepares the operands for an iterative divide that runs afterwards. It takes a 32-bit dividend and a 32-bit divisor, along with a variant code and a core-version select. The variant code picks the operand size (word, halfword or byte) and whether the operation is signed or unsigned. The block packs the dividend into a 64-bit register-pair value, given as a low and a high 32-bit word. For signed operations it also places a sign-fill pattern in that value. The divide steps that follow start from this value.

For byte and halfword divides on the older core version, the block also predicts quotient overflow early. It does this with a magnitude comparison. Three status flags record the outcome: overflow, sticky overflow and advance overflow. These flags are registered and change only on a cycle with the valid strobe. The packed result is combinational and can be read in the same cycle as the strobe.

Top module: `div_prep`

## Requirements
- R1: After a synchronous active-high reset, the overflow, sticky and advance flags all read 0.
- R2: Variant code is {unsigned bit [2], size [1:0]}, where size 0 is word, 1 is halfword, 2 is byte and 3 acts as word. For the word size, the low word equals the dividend. The high word is the dividend's sign extension when signed, and 0 when unsigned.
- R3: Signed byte: the 64-bit value {hi,lo} is the sign-extended dividend shifted left by 24. When dividend bit 31 differs from divisor bit 31, lo[23:0] is forced to all ones.
- R4: Signed halfword: {hi,lo} is the sign-extended dividend shifted left by 16. When the sign bits of the two operands differ, lo[15:0] is forced to all ones.
- R5: Unsigned byte or halfword: hi is the dividend logically shifted right by 8 (byte) or 16 (halfword), and lo is the dividend shifted left by 24 (byte) or 16 (halfword). No fill is applied.
- R6: Older version (legacy_i = 1), signed byte or halfword: the new overflow is 1 when |dividend| >> 8 (byte) or >> 16 (halfword) is greater than or equal to |divisor|. Each magnitude is the 32-bit two's-complement negation of a negative operand, compared as unsigned, so |0x80000000| = 0x80000000.
- R7: Older version, unsigned byte or halfword: the new overflow is 1 when the new high word (from R5) is greater than or equal to |divisor|, where the divisor magnitude is taken as in R6.
- R8: The new overflow is 0 for every word-size variant, and for every variant on the newer version (legacy_i = 0).
- R9: On each cycle with valid_i high, the next clock edge loads the overflow flag with the new overflow, sets the sticky flag to its old value ORed with the new overflow, and clears the advance flag.
- R10: While valid_i is low, all three flags hold their values. The packed result follows the inputs combinationally, whether or not valid_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Strobe that commits the flag updates |
| dividend_i | input | 32 | Dividend operand |
| divisor_i | input | 32 | Divisor operand |
| variant_i | input | 3 | {unsigned, size[1:0]} |
| legacy_i | input | 1 | 1 selects the older core version's overflow rules |
| res_lo_o | output | 32 | Low word of the packed register pair |
| res_hi_o | output | 32 | High word of the packed register pair |
| ovf_o | output | 1 | Overflow flag |
| sticky_o | output | 1 | Sticky overflow flag |
| adv_o | output | 1 | Advance overflow flag |

## Verification
The assertions check the flag rules on every cycle: sticky never falls, overflow implies sticky, the advance flag is cleared after each strobe, the flags stay stable with no strobe, and overflow is never raised for the word size or the newer version. They also check the sign-extended high word on signed word packing. Only the bench scenarios can show that the packing shifts and the sign fill are correct for byte and halfword. The same holds for where the magnitude comparison flips at its boundary, including operands of 0x80000000 and a zero divisor.

// File: rtl/div_prep_pkg.sv
package div_prep_pkg;
    localparam int DW     = 32;
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;
    localparam int BYTE_L = DW - BYTE_W;
    localparam int HALF_L = DW - HALF_W;

    typedef enum logic [1:0] {
        SZ_WORD = 2'd0,
        SZ_HALF = 2'd1,
        SZ_BYTE = 2'd2,
        SZ_WRD2 = 2'd3
    } size_e;

    typedef struct packed {
        logic  uns;
        size_e size;
    } variant_t;

    typedef struct packed {
        logic [DW-1:0] hi;
        logic [DW-1:0] lo;
    } pair_t;

    function automatic logic [DW-1:0] mag(input logic [DW-1:0] x);
        return x[DW-1] ? (~x + 1'b1) : x;
    endfunction
endpackage

// File: rtl/div_prep_pack.sv
module div_prep_pack
    import div_prep_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic [DW-1:0] dvd,
    input  logic [DW-1:0] dvs,
    input  variant_t var_sel,
    output pair_t    pair
);
    logic sign_diff;
    assign sign_diff = dvd[DW-1] ^ dvs[DW-1];

    always_comb begin
        pair = '0;
        unique case (var_sel.size)
            SZ_HALF: begin
                pair.lo = dvd << HALF_L;
                if (var_sel.uns) begin
                    pair.hi = dvd >> HALF_W;
                end else begin
                    pair.hi = $unsigned($signed(dvd) >>> HALF_W);
                    if (sign_diff) pair.lo[HALF_L-1:0] = '1;
                end
            end
            SZ_BYTE: begin
                pair.lo = dvd << BYTE_L;
                if (var_sel.uns) begin
                    pair.hi = dvd >> BYTE_W;
                end else begin
                    pair.hi = $unsigned($signed(dvd) >>> BYTE_W);
                    if (sign_diff) pair.lo[BYTE_L-1:0] = '1;
                end
            end
            default: begin
                pair.lo = dvd;
                pair.hi = var_sel.uns ? '0 : {DW{dvd[DW-1]}};
            end
        endcase
    end

    // R2
    word_sext_chk: assert property (@(posedge clk) disable iff (rst)
        (!var_sel.uns && (var_sel.size == SZ_WORD)) |-> (pair.hi == {DW{pair.lo[DW-1]}}));
endmodule

// File: rtl/div_prep_ovf.sv
module div_prep_ovf
    import div_prep_pkg::*;
(
    input  logic          legacy,
    input  logic [DW-1:0] dvd,
    input  logic [DW-1:0] dvs,
    input  variant_t      var_sel,
    output logic          ovf_new
);
    logic [DW-1:0] base;
    logic [DW-1:0] top;
    logic [DW-1:0] dvs_mag;

    always_comb begin
        base    = var_sel.uns ? dvd : mag(dvd);
        dvs_mag = mag(dvs);
        top     = '0;
        ovf_new = 1'b0;
        unique case (var_sel.size)
            SZ_HALF: top = base >> HALF_W;
            SZ_BYTE: top = base >> BYTE_W;
            default: top = '0;
        endcase
        if (legacy && (var_sel.size inside {SZ_HALF, SZ_BYTE}))
            ovf_new = (top >= dvs_mag);
    end
endmodule

// File: rtl/div_prep_flags.sv
module div_prep_flags (
    input  logic clk,
    input  logic rst,
    input  logic valid,
    input  logic legacy,
    input  logic word_sz,
    input  logic ovf_new,
    output logic ovf_q,
    output logic sticky_q,
    output logic adv_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q    <= 1'b0;
            sticky_q <= 1'b0;
            adv_q    <= 1'b0;
        end else if (valid) begin
            ovf_q    <= ovf_new;
            sticky_q <= sticky_q | ovf_new;
            adv_q    <= 1'b0;
        end
    end

    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sticky_q |=> sticky_q);
    // R9
    ovf_implies_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_q |-> sticky_q);
    // R9
    adv_clear_chk: assert property (@(posedge clk) disable iff (rst)
        valid |=> !adv_q);
    // R10
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !valid |=> ($stable(ovf_q) && $stable(sticky_q) && $stable(adv_q)));
    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && (!legacy || word_sz)) |=> !ovf_q);
endmodule

// File: rtl/div_prep.sv
module div_prep
    import div_prep_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          valid_i,
    input  logic [31:0]   dividend_i,
    input  logic [31:0]   divisor_i,
    input  logic [2:0]    variant_i,
    input  logic          legacy_i,
    output logic [31:0]   res_lo_o,
    output logic [31:0]   res_hi_o,
    output logic          ovf_o,
    output logic          sticky_o,
    output logic          adv_o
);
    variant_t var_sel;
    pair_t    pair;
    logic     ovf_new;
    logic     word_sz;

    assign var_sel = variant_t'(variant_i);
    assign word_sz = (var_sel.size == SZ_WORD) || (var_sel.size == SZ_WRD2);

    div_prep_pack u_pack (
        .clk     (clk),
        .rst     (rst),
        .dvd     (dividend_i),
        .dvs     (divisor_i),
        .var_sel (var_sel),
        .pair    (pair)
    );

    div_prep_ovf u_ovf (
        .legacy  (legacy_i),
        .dvd     (dividend_i),
        .dvs     (divisor_i),
        .var_sel (var_sel),
        .ovf_new (ovf_new)
    );

    div_prep_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .valid    (valid_i),
        .legacy   (legacy_i),
        .word_sz  (word_sz),
        .ovf_new  (ovf_new),
        .ovf_q    (ovf_o),
        .sticky_q (sticky_o),
        .adv_q    (adv_o)
    );

    assign res_lo_o = pair.lo;
    assign res_hi_o = pair.hi;
endmodule

// File: tb/div_prep_tb.sv
module div_prep_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [31:0] dividend_i = '0;
    logic [31:0] divisor_i = '0;
    logic [2:0]  variant_i = '0;
    logic        legacy_i = 1'b0;
    logic [31:0] res_lo_o, res_hi_o;
    logic        ovf_o, sticky_o, adv_o;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic  v;
        logic  sv;
        logic  av;
        string req;
    } flag_item_t;

    flag_item_t sb_q[$];
    logic m_v = 0, m_sv = 0, m_av = 0;

    always #2.5 clk = ~clk;

    div_prep dut_i (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] absu(input logic [31:0] x);
        return x[31] ? (32'd0 - x) : x;
    endfunction

    task automatic run(input string req, input logic [31:0] a, input logic [31:0] b,
                       input logic uns, input logic [1:0] sz, input logic leg, input logic vld);
        logic [63:0] exp_pair;
        logic        exp_ov;
        int          sh;
        @(negedge clk);
        dividend_i = a; divisor_i = b; variant_i = {uns, sz}; legacy_i = leg; valid_i = vld;
        sh = (sz == 2'd2) ? 24 : (sz == 2'd1) ? 16 : 0;
        exp_ov = 1'b0;
        if (sh == 0) begin
            exp_pair = uns ? {32'd0, a} : {{32{a[31]}}, a};
        end else if (uns) begin
            exp_pair = {a, 32'd0} >> (32 - sh);
            exp_pair[31:0] = a << sh;
            if (leg) exp_ov = ((a >> (32 - sh)) >= absu(b));
        end else begin
            exp_pair = {{32{a[31]}}, a} << sh;
            if (a[31] != b[31]) exp_pair = exp_pair | ((64'd1 << sh) - 1);
            if (leg) exp_ov = ((absu(a) >> (32 - sh)) >= absu(b));
        end
        #1;
        check({req, " pair"}, {res_hi_o, res_lo_o}, exp_pair);
        if (vld) begin
            m_v = exp_ov; m_sv = m_sv | exp_ov; m_av = 1'b0;
        end
        sb_q.push_back('{m_v, m_sv, m_av, req});
    endtask

    initial begin : monitor
        flag_item_t it;
        forever begin
            @(negedge clk);
            if (sb_q.size() != 0) begin
                it = sb_q.pop_front();
                check({it.req, " flags"}, {61'd0, ovf_o, sticky_o, adv_o},
                      {61'd0, it.v, it.sv, it.av});
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        #1;
        // R1
        check("R1 reset flags", {61'd0, ovf_o, sticky_o, adv_o}, 64'd0);
        @(negedge clk);
        rst = 1'b0;
        // R2 word variants
        run("R2", 32'h8000_1234, 32'h5, 1'b0, 2'd0, 1'b1, 1'b1);
        run("R2", 32'h8000_1234, 32'h5, 1'b1, 2'd0, 1'b1, 1'b1);
        run("R2", 32'h7FFF_0000, 32'hF, 1'b0, 2'd3, 1'b1, 1'b1);
        // R3 signed byte, same and different signs
        run("R3", 32'h1234_5678, 32'h0000_0010, 1'b0, 2'd2, 1'b1, 1'b1);
        run("R3", 32'hFFFF_FF00, 32'h0000_0005, 1'b0, 2'd2, 1'b1, 1'b1);
        // R4 signed halfword
        run("R4", 32'hFFFE_0000, 32'hFFFF_FFFC, 1'b0, 2'd1, 1'b1, 1'b1);
        run("R4", 32'h0003_0000, 32'hFFFF_FFFD, 1'b0, 2'd1, 1'b1, 1'b1);
        // R6 boundary: |a|>>8 == |b| and one below
        run("R6", 32'h0000_0500, 32'hFFFF_FFFB, 1'b0, 2'd2, 1'b1, 1'b1);
        run("R6", 32'h0000_04FF, 32'hFFFF_FFFB, 1'b0, 2'd2, 1'b1, 1'b1);
        run("R6", 32'h8000_0000, 32'h8000_0000, 1'b0, 2'd1, 1'b1, 1'b1);
        run("R6", 32'h0000_0001, 32'h0000_0000, 1'b0, 2'd2, 1'b1, 1'b1);
        // R5 / R7 unsigned
        run("R5", 32'hDEAD_BEEF, 32'hFFFF_FFFF, 1'b1, 2'd2, 1'b1, 1'b1);
        run("R7", 32'h0004_0000, 32'h0000_0004, 1'b1, 2'd1, 1'b1, 1'b1);
        run("R7", 32'h0003_FFFF, 32'h0000_0004, 1'b1, 2'd1, 1'b1, 1'b1);
        run("R7", 32'hFFFF_0000, 32'h8000_0000, 1'b1, 2'd1, 1'b1, 1'b1);
        // R8 newer version
        run("R8", 32'h7FFF_FFFF, 32'h1, 1'b0, 2'd2, 1'b0, 1'b1);
        run("R8", 32'h7FFF_FFFF, 32'h1, 1'b1, 2'd1, 1'b0, 1'b1);
        // R9 set overflow, then clear it, sticky stays
        run("R9", 32'h0100_0000, 32'h2, 1'b0, 2'd1, 1'b1, 1'b1);
        run("R9", 32'h0000_0010, 32'h2, 1'b0, 2'd1, 1'b1, 1'b1);
        // R10 overflow-causing inputs without strobe, flags hold
        run("R10", 32'h0100_0000, 32'h2, 1'b0, 2'd2, 1'b1, 1'b0);
        run("R10", 32'h0000_0000, 32'h2, 1'b1, 2'd1, 1'b1, 1'b0);
        // R1 reset clears sticky
        @(negedge clk);
        rst = 1'b1; valid_i = 1'b0;
        @(negedge clk);
        #1;
        check("R1 reset again", {61'd0, ovf_o, sticky_o, adv_o}, 64'd0);
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule